// File: doc/BRIEF.md
# Sense-Configurable 32-Line Interrupt Controller

This block gathers 32 asynchronous interrupt lines and turns them into two request outputs for a processor: a critical one and a normal (non-critical) one. For each line, software chooses whether it is edge- or level-sensitive and which polarity counts as active. It also chooses whether the line may raise a request at all, and which of the two outputs it drives. All of this is set through a small word-addressed register bus with combinational read data and single-cycle writes.

Edge-triggered lines latch a pending bit that software acknowledges by writing a 1 to it. Level-triggered lines show the present line state. Software finds the pending, enabled lines by reading the masked view. Every input is synchronised before it is used. Register bits are numbered from the top, so line n occupies bit 31-n of every register.

Top module: `intc_sense32`

## Requirements
- R1: After reset, the enable (offset 0x2), routing (0x3), polarity (0x4) and trigger (0x5) registers read zero, and both request outputs are low.
- R2: Line n is reported and configured at register bit 31-n in every register, so line 0 is the most significant bit.
- R3: With trigger bit 0 (level), the status bit at offset 0x0 is 1 exactly while the synchronised line is active: high when the polarity bit is 1, low when it is 0. Writing 1 to that status bit has no effect while the line stays active.
- R4: With trigger bit 1 (edge), the status bit sets on a rising edge when the polarity bit is 1 and on a falling edge when it is 0. The bit stays set after the line returns, until a 1 is written to it at offset 0x0. Writing 0 to a status bit leaves it unchanged.
- R5: If an edge is detected in the same cycle that a clearing write hits the same status bit, the bit ends up set.
- R6: Offset 0x6 reads status AND enable. Writes to 0x6 change nothing.
- R7: The critical output is the registered OR of masked bits whose routing bit is 1. The normal output is the registered OR of masked bits whose routing bit is 0.
- R8: Reads of offsets 0x1, 0x7, 0x8 and 0x9 to 0xF return zero.
- R9: A line change reaches the status register on the third rising clock edge after it is applied (two synchroniser flops plus the status flop), and reaches the outputs one edge later.
- R10: Writing zero to the enable register forces both outputs low by the second rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_in | input | 32 | Asynchronous interrupt lines, index n is line n |
| irq_nc | output | 1 | Normal request |
| irq_crit | output | 1 | Critical request |

## Verification
The hardest case to reach is the race between a freshly detected edge and a clearing write on the same bit. The edge only appears inside the block, two flops after the input changes. The stimulus raises the line and then puts the clear write exactly in the third cycle, so both land on the same clock edge. The other checks sweep all 32 lines under each of the four trigger/polarity modes, and a fixed alternating routing pattern exercises both outputs.

// File: rtl/intc_sense32.sv
module intc_sense32 #(
  parameter int NSRC = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  input  logic [NSRC-1:0] irq_in,
  output logic            irq_nc,
  output logic            irq_crit
);

  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(2);
  localparam logic [AW-1:0] A_CRIT = AW'(3);
  localparam logic [AW-1:0] A_POL  = AW'(4);
  localparam logic [AW-1:0] A_TRIG = AW'(5);
  localparam logic [AW-1:0] A_MSK  = AW'(6);

  logic [NSRC-1:0] line_b, s1, s2, s3;
  logic [NSRC-1:0] stat, en, crit, pol, trig;
  logic [NSRC-1:0] act, edge_hit, clr, masked;

  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign line_b[NSRC-1-n] = irq_in[n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= line_b;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign act      = ~(s2 ^ pol);
  assign edge_hit = (pol & s2 & ~s3) | (~pol & ~s2 & s3);
  assign clr      = (wr_en && addr == A_STAT) ? wdata : '0;
  assign masked   = stat & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
      crit <= '0;
      pol  <= '0;
      trig <= '0;
    end else begin
      stat <= (~trig & act) | (trig & (edge_hit | (stat & ~clr)));
      if (wr_en) begin
        case (addr)
          A_EN:    en   <= wdata;
          A_CRIT:  crit <= wdata;
          A_POL:   pol  <= wdata;
          A_TRIG:  trig <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = stat;
      A_EN:    rdata = en;
      A_CRIT:  rdata = crit;
      A_POL:   rdata = pol;
      A_TRIG:  rdata = trig;
      A_MSK:   rdata = masked;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_nc   <= 1'b0;
      irq_crit <= 1'b0;
    end else begin
      irq_nc   <= |(masked & ~crit);
      irq_crit <= |(masked & crit);
    end
  end

  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> ((stat & $past(stat & trig)) == $past(stat & trig)));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |(edge_hit & trig) |=> ((stat & $past(edge_hit & trig)) == $past(edge_hit & trig)));

  p_msk_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSK) |=> ($stable(en) && $stable(crit) && $stable(pol) && $stable(trig)));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(1) || addr > A_MSK) |-> (rdata == '0));

  p_disable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EN && wdata == '0) |=> ##1 (!irq_nc && !irq_crit));

endmodule

// File: tb/intc_sense32_tb.sv
module intc_sense32_tb;
  localparam int CLK_NS = 10;
  localparam int N = 32;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata, irq_in = '0;
  logic irq_nc, irq_crit;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  intc_sense32 u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .irq_nc(irq_nc), .irq_crit(irq_crit));

  task automatic chk(input logic [N-1:0] got, input logic [N-1:0] exp, input string tag);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] cpat;
    cpat = 32'hAAAA5555;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(4'h2, v); chk(v, '0, "R1 enable");
    rd(4'h3, v); chk(v, '0, "R1 routing");
    rd(4'h4, v); chk(v, '0, "R1 polarity");
    rd(4'h5, v); chk(v, '0, "R1 trigger");
    chk({30'd0, irq_nc, irq_crit}, '0, "R1 outputs");

    // R8 unmapped offsets
    wr(4'h5, 32'h12345678);
    for (int a = 1; a < 16; a++)
      if (a == 1 || a > 6) begin rd(a[3:0], v); chk(v, '0, $sformatf("R8 offset %0d", a)); end
    wr(4'h5, '0);

    // R2 R3 R4 sweep all lines in every mode
    for (int m = 0; m < 4; m++) begin
      logic tg, pl;
      tg = m[1]; pl = m[0];
      wr(4'h4, {N{pl}});
      wr(4'h5, {N{tg}});
      irq_in = {N{~pl}};
      idle(5);
      wr(4'h0, '1);
      rd(4'h0, v); chk(v, '0, $sformatf("R4 R3 idle mode %0d", m));
      for (int n = 0; n < N; n++) begin
        logic [N-1:0] bit_n;
        bit_n = 32'h8000_0000 >> n;
        irq_in[n] = pl;
        idle(3);
        rd(4'h0, v); chk(v, bit_n, $sformatf("R2 R9 line %0d mode %0d", n, m));
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk(v, bit_n, $sformatf("R4 zero write line %0d", n));
        wr(4'h0, bit_n);
        rd(4'h0, v); chk(v, tg ? '0 : bit_n, $sformatf("R3 R4 clear while active line %0d mode %0d", n, m));
        if (tg) begin
          irq_in[n] = ~pl; idle(4);
          rd(4'h0, v); chk(v, '0, $sformatf("R4 no set on opposite edge line %0d", n));
          irq_in[n] = pl; idle(4);
          irq_in[n] = ~pl; idle(4);
          rd(4'h0, v); chk(v, bit_n, $sformatf("R4 held after release line %0d", n));
          wr(4'h0, bit_n);
        end else begin
          irq_in[n] = ~pl; idle(4);
        end
        rd(4'h0, v); chk(v, '0, $sformatf("R3 R4 released line %0d mode %0d", n, m));
      end
    end

    // R6 R7 masking and routing, level active-high
    wr(4'h4, '1); wr(4'h5, '0); irq_in = '0;
    wr(4'h3, cpat); wr(4'h2, '1); idle(4);
    for (int n = 0; n < N; n++) begin
      logic [N-1:0] bit_n;
      bit_n = 32'h8000_0000 >> n;
      irq_in[n] = 1; idle(4);
      rd(4'h6, v); chk(v, bit_n, $sformatf("R6 masked line %0d", n));
      chk({30'd0, irq_crit, irq_nc}, {30'd0, |(cpat & bit_n), ~|(cpat & bit_n)},
          $sformatf("R7 routing line %0d", n));
      irq_in[n] = 0; idle(4);
      chk({30'd0, irq_crit, irq_nc}, '0, $sformatf("R7 quiet line %0d", n));
    end
    irq_in[5] = 1;
    wr(4'h2, ~(32'h8000_0000 >> 5)); idle(2);
    rd(4'h6, v); chk(v, '0, "R6 disabled line masked");
    rd(4'h0, v); chk(v, 32'h8000_0000 >> 5, "R3 status ignores enable");
    wr(4'h6, '0);
    rd(4'h2, v); chk(v, ~(32'h8000_0000 >> 5), "R6 write to masked ignored");
    wr(4'h2, '1); idle(2);
    chk({31'd0, irq_nc}, 32'd1, "R7 normal request");
    wr(4'h2, '0); idle(1);
    chk({30'd0, irq_nc, irq_crit}, '0, "R10 disable clears outputs");
    irq_in[5] = 0; idle(4);

    // R5 edge and clear on the same edge
    wr(4'h5, '1); idle(4); wr(4'h0, '1);
    @(negedge clk); irq_in[9] = 1;
    @(negedge clk); @(negedge clk);
    addr = 4'h0; wdata = '1; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(4'h0, v); chk(v, 32'h8000_0000 >> 9, "R5 set beats clear");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule